// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block returns the smaller or the larger of two IEEE 754 operands, in single precision (32-bit) or double precision (64-bit), chosen per operation. The ordering follows the minimumNumber/maximumNumber rules:
- negative zero counts as smaller than positive zero;
- a lone NaN operand gives way to the numeric operand;
- a canonical quiet NaN is produced only when neither operand is a number.

An invalid-operation flag reports any signaling NaN input. The flag never changes the selected result.

The selection logic is combinational and is followed by one registered output stage. Operations enter on a valid/ready stream and leave on a second valid/ready stream.

Back-pressure rules:
- An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). An operation can therefore be accepted every cycle while the consumer keeps `out_ready` high.
- While `out_valid` is high and `out_ready` is low, the output word and flag hold their values and no new operation is taken.

Top module: `fp_minmax_unit`

## Requirements
- R1: With `in_fmt`=0 (single), only bits [31:0] of each operand are examined, and result bits [63:32] are all ones. With `in_fmt`=1 (double), all 64 bits are used.
- R2: For two non-NaN operands of different value, `in_op`=0 returns the numerically smaller operand and `in_op`=1 returns the larger one, bit-exact. Infinities are ordered as the extreme values.
- R3: Negative zero orders below positive zero. min of {+0, -0} in either order returns -0, and max returns +0.
- R4: When exactly one operand is a NaN (exponent all ones, fraction nonzero), the other operand is returned unchanged.
- R5: When both operands are NaN, the result is the canonical NaN. For single precision this is 0x7FC00000, boxed to 0xFFFFFFFF7FC00000. For double precision it is 0x7FF8000000000000.
- R6: `out_invalid` is 1 exactly when an operand is a signaling NaN (NaN with the fraction MSB clear). A quiet NaN alone leaves it 0. The flag never replaces the selected result.
- R7: The result and flag of an accepted operation appear with `out_valid`=1 one cycle after acceptance. `out_valid` drops after a drain with no new acceptance.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output word and flag stay stable. Otherwise `in_ready` is 1, which allows one operation per cycle.
- R9: After reset, `out_valid`, `out_invalid` and `out_result` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_op | input | 1 | 0 = minimum, 1 = maximum |
| in_fmt | input | 1 | 0 = single precision, 1 = double precision |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Selected or canonical value |
| out_invalid | output | 1 | Signaling NaN seen on an input |

## Verification
Random operands are drawn from a mix of the following:
- signed zeros and infinities;
- quiet and signaling NaNs with random payloads;
- an operand paired with a copy of itself or with its negation;
- ordinary random bit patterns.

These pairs separate ordinary ordering from the signed-zero tie rule, and the one-NaN case from the two-NaN case. They also separate a quiet NaN from a signaling NaN in the flag. Single-precision operands carry random upper halves, which exposes any use of the unexamined bits or a missing box. Directed cases cover the exact canonical words and the -0/+0 pairs. A stream with random `in_valid` and `out_ready` distinguishes correct holding under back-pressure from lost or repeated results.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int WORD_W    = 64;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int MAG_W     = WORD_W - 1;
  localparam int BOX_W     = WORD_W - SP_W;

  typedef enum logic {OP_MIN = 1'b0, OP_MAX = 1'b1} op_e;
  typedef enum logic {FMT_SP = 1'b0, FMT_DP = 1'b1} fmt_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic [MAG_W-1:0] mag;
  } opnd_info_t;

  // Canonical quiet NaN: positive, exponent all ones, only quiet bit set
  localparam logic [SP_W-1:0] SP_QNAN =
    {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] DP_QNAN =
    {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] SP_QNAN_BOXED = {{BOX_W{1'b1}}, SP_QNAN};
endpackage

// File: rtl/fpmm_field_decode.sv
module fpmm_field_decode #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int BITS_W = 1 + EXP_W + FRAC_W
) (
  input  logic [BITS_W-1:0]   bits,
  output logic                sign,
  output logic                is_nan,
  output logic                is_snan,
  output logic                is_zero,
  output logic [BITS_W-2:0]   mag
);
  logic exp_ones;
  logic frac_nz;
  logic quiet_bit;

  always_comb begin
    sign      = bits[BITS_W-1];
    mag       = bits[BITS_W-2:0];
    exp_ones  = &bits[BITS_W-2:FRAC_W];
    frac_nz   = |bits[FRAC_W-1:0];
    quiet_bit = bits[FRAC_W-1];
    is_nan    = exp_ones & frac_nz;
    is_snan   = exp_ones & frac_nz & ~quiet_bit;
    is_zero   = ~|bits[BITS_W-2:0];
  end
endmodule

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  fmt_e              fmt,
  output opnd_info_t        info
);
  localparam int N_FMT = 2;

  opnd_info_t fmt_info [N_FMT];

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? SP_EXP_W : DP_EXP_W;
    localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
    localparam int BW = 1 + EW + FW;
    logic          s, n, sn, z;
    logic [BW-2:0] m;

    fpmm_field_decode #(.EXP_W(EW), .FRAC_W(FW)) u_dec (
      .bits    (word[BW-1:0]),
      .sign    (s),
      .is_nan  (n),
      .is_snan (sn),
      .is_zero (z),
      .mag     (m)
    );

    always_comb begin
      fmt_info[g].sign    = s;
      fmt_info[g].is_nan  = n;
      fmt_info[g].is_snan = sn;
      fmt_info[g].is_zero = z;
      fmt_info[g].mag     = MAG_W'(m);
    end
  end

  assign info = (fmt == FMT_DP) ? fmt_info[1] : fmt_info[0];
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  opnd_info_t a,
  input  opnd_info_t b,
  output logic       a_lt_b,
  output logic       b_lt_a,
  output logic       a_eq_b
);
  logic any_nan;
  logic both_zero;
  logic mag_lt;
  logic mag_gt;
  logic mag_eq;

  always_comb begin
    any_nan   = a.is_nan | b.is_nan;
    both_zero = a.is_zero & b.is_zero;
    mag_lt    = a.mag < b.mag;
    mag_gt    = b.mag < a.mag;
    mag_eq    = a.mag == b.mag;
    // Quiet comparisons: any NaN makes every relation false
    a_eq_b = ~any_nan & (both_zero | ((a.sign == b.sign) & mag_eq));
    a_lt_b = 1'b0;
    b_lt_a = 1'b0;
    if (!any_nan && !both_zero) begin
      if (a.sign != b.sign) begin
        a_lt_b = a.sign;
        b_lt_a = b.sign;
      end else if (a.sign) begin
        a_lt_b = mag_gt;
        b_lt_a = mag_lt;
      end else begin
        a_lt_b = mag_lt;
        b_lt_a = mag_gt;
      end
    end
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
(
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  opnd_info_t        a,
  input  opnd_info_t        b,
  input  logic              a_lt_b,
  input  logic              b_lt_a,
  input  logic              a_eq_b,
  input  op_e               op,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  logic              a_wins;
  logic [WORD_W-1:0] chosen;

  always_comb begin
    // Ties between equal values are broken by sign so -0 < +0
    if (op == OP_MIN) a_wins = a_lt_b | (a_eq_b & a.sign);
    else              a_wins = b_lt_a | (a_eq_b & b.sign);
    a_wins = a_wins | b.is_nan;
    chosen = a_wins ? a_word : b_word;

    if (a.is_nan && b.is_nan)
      result = (fmt == FMT_DP) ? DP_QNAN : SP_QNAN_BOXED;
    else if (fmt == FMT_DP)
      result = chosen;
    else
      result = {{BOX_W{1'b1}}, chosen[SP_W-1:0]};

    invalid = a.is_snan | b.is_snan;
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_op,
  input  logic              in_fmt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid
);
  fmt_e              fmt;
  op_e               op;
  opnd_info_t        info_a;
  opnd_info_t        info_b;
  logic              lt_ab;
  logic              lt_ba;
  logic              eq_ab;
  logic [WORD_W-1:0] res_d;
  logic              inv_d;
  logic              accept;

  assign fmt = fmt_e'(in_fmt);
  assign op  = op_e'(in_op);

  fpmm_classify u_cls_a (.word(in_a), .fmt(fmt), .info(info_a));
  fpmm_classify u_cls_b (.word(in_b), .fmt(fmt), .info(info_b));

  fpmm_order u_order (
    .a(info_a), .b(info_b),
    .a_lt_b(lt_ab), .b_lt_a(lt_ba), .a_eq_b(eq_ab)
  );

  fpmm_pick u_pick (
    .a_word(in_a), .b_word(in_b), .a(info_a), .b(info_b),
    .a_lt_b(lt_ab), .b_lt_a(lt_ba), .a_eq_b(eq_ab),
    .op(op), .fmt(fmt), .result(res_d), .invalid(inv_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res_d;
      out_invalid <= inv_d;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_minmax_unit_checker.sv
module fp_minmax_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_a,
  input logic [63:0] in_b,
  input logic        in_op,
  input logic        in_fmt,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid
);
  function automatic logic nan_of(logic [63:0] w, logic dp);
    if (dp) return (w[62:52] == 11'h7FF) && (w[51:0] != 52'd0);
    return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
  endfunction

  function automatic logic snan_of(logic [63:0] w, logic dp);
    return nan_of(w, dp) && (dp ? !w[51] : !w[22]);
  endfunction

  logic acc;
  assign acc = in_valid && in_ready;

  p_box_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_fmt |=> out_result[63:32] == 32'hFFFF_FFFF);

  p_one_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_fmt && nan_of(in_b, 1'b1) && !nan_of(in_a, 1'b1)
    |=> out_result == $past(in_a));

  p_canon_dp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_fmt && nan_of(in_a, 1'b1) && nan_of(in_b, 1'b1)
    |=> out_result == 64'h7FF8_0000_0000_0000);

  p_canon_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_fmt && nan_of(in_a, 1'b0) && nan_of(in_b, 1'b0)
    |=> out_result == 64'hFFFF_FFFF_7FC0_0000);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !snan_of(in_a, in_fmt) && !snan_of(in_b, in_fmt) |=> !out_invalid);

  p_snan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (snan_of(in_a, in_fmt) || snan_of(in_b, in_fmt)) |=> out_invalid);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && out_ready |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready
    |=> out_valid && $stable(out_result) && $stable(out_invalid));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind fp_minmax_unit fp_minmax_unit_checker u_checker (.*);

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        in_op = 1'b0;
  logic        in_fmt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fp_minmax_unit uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected finish", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- reference model ----------------
  function automatic bit is_nan(logic [63:0] w, bit dp);
    if (dp) return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [63:0] w, bit dp);
    return is_nan(w, dp) && (dp ? (w[51] == 1'b0) : (w[22] == 1'b0));
  endfunction

  // Monotone unsigned key: negative values inverted, positives get top bit set
  function automatic logic [63:0] okey(logic [63:0] w, bit dp);
    logic [63:0] v;
    v = dp ? w : {32'd0, w[31:0]};
    if (dp) return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
    return {32'd0, v[31] ? ~v[31:0] : (v[31:0] | 32'h8000_0000)};
  endfunction

  function automatic logic [63:0] ref_res(logic [63:0] a, logic [63:0] b,
                                          bit op, bit dp);
    logic [63:0] r;
    logic [63:0] ka, kb;
    ka = okey(a, dp);
    kb = okey(b, dp);
    if (is_nan(a, dp) && is_nan(b, dp))
      r = dp ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
    else if (is_nan(a, dp)) r = b;
    else if (is_nan(b, dp)) r = a;
    else if (!op)           r = (ka <= kb) ? a : b;
    else                    r = (ka >= kb) ? a : b;
    if (!dp) r = {32'hFFFF_FFFF, r[31:0]};
    return r;
  endfunction

  function automatic string tag_of(logic [63:0] a, logic [63:0] b, bit dp);
    string t;
    if (is_snan(a, dp) || is_snan(b, dp))    t = "R6";
    else if (is_nan(a, dp) && is_nan(b, dp)) t = "R5";
    else if (is_nan(a, dp) || is_nan(b, dp)) t = "R4";
    else if (okey(a, dp) == okey(b, dp) ^ 1'b0 &&
             (dp ? a[62:0] == 0 : a[30:0] == 0)) t = "R3";
    else                                     t = "R2";
    if (!dp) t = {t, "/R1"};
    return t;
  endfunction

  function automatic logic [63:0] gen_val(bit dp);
    logic [63:0] w;
    int k;
    logic s;
    k = $urandom % 9;
    s = $urandom % 2;
    w = {$urandom, $urandom};
    if (dp) begin
      case (k)
        0: w = {s, 63'd0};
        1: w = {s, 11'h7FF, 52'd0};
        2: w = {s, 11'h7FF, 1'b1, w[50:0]};
        3: w = {s, 11'h7FF, 1'b0, w[50:1], 1'b1};
        default: ;
      endcase
    end else begin
      case (k)
        0: w[31:0] = {s, 31'd0};
        1: w[31:0] = {s, 8'hFF, 23'd0};
        2: w[31:0] = {s, 8'hFF, 1'b1, w[21:0]};
        3: w[31:0] = {s, 8'hFF, 1'b0, w[21:1], 1'b1};
        default: ;
      endcase
    end
    return w;
  endfunction

  task automatic check(string req, string what, logic [63:0] act,
                       logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Single operation with open output; result sampled one cycle later
  task automatic run_one(logic [63:0] a, logic [63:0] b, bit op, bit dp,
                         logic [63:0] exp_r, bit exp_i, string req);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_fmt = dp;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", "out_valid after accept", 64'(out_valid), 64'd1);
    check(req, "result", out_result, exp_r);
    check(req, "invalid", 64'(out_invalid), 64'(exp_i));
  endtask

  logic [63:0] exp_q [$];
  logic        inv_q [$];
  string       tag_q [$];

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", "out_valid", 64'(out_valid), 64'd0);
    check("R9", "out_result", out_result, 64'd0);
    check("R9", "out_invalid", 64'(out_invalid), 64'd0);
    check("R9", "in_ready", 64'(in_ready), 64'd1);

    // Directed corners
    run_one(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1,
            64'h8000_0000_0000_0000, 0, "R3");
    run_one(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 1, 1,
            64'h0000_0000_0000_0000, 0, "R3");
    run_one(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 1,
            64'h0000_0000_0000_0000, 0, "R3");
    run_one(64'h1234_5678_8000_0000, 64'hABCD_0000_0000_0000, 0, 0,
            64'hFFFF_FFFF_8000_0000, 0, "R3/R1");
    run_one(64'h7FF8_0000_0000_0001, 64'h3FF0_0000_0000_0000, 0, 1,
            64'h3FF0_0000_0000_0000, 0, "R4");
    run_one(64'h4000_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1, 1,
            64'h4000_0000_0000_0000, 1, "R6");
    run_one(64'h7FF8_1234_0000_0000, 64'hFFF8_0000_0000_0000, 0, 1,
            64'h7FF8_0000_0000_0000, 0, "R5");
    run_one(64'h0000_0000_7FC1_0000, 64'h5555_5555_FFC0_0001, 1, 0,
            64'hFFFF_FFFF_7FC0_0000, 0, "R5/R1");
    run_one(64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0002, 1, 1,
            64'h7FF8_0000_0000_0000, 1, "R5/R6");
    run_one(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 0, 1,
            64'hC000_0000_0000_0000, 0, "R2");
    run_one(64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 1,
            64'h3FF0_0000_0000_0000, 0, "R2");
    run_one(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 1, 1,
            64'h7FF0_0000_0000_0000, 0, "R2");
    run_one(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 0, 0,
            64'hFFFF_FFFF_3F80_0000, 0, "R1");

    // R7: drained with no new acceptance -> out_valid low
    @(negedge clk);
    check("R7", "out_valid after drain", 64'(out_valid), 64'd0);

    // R8 directed hold: result held under stall, second op waits
    @(negedge clk);
    in_a = 64'h3FF0_0000_0000_0000; in_b = 64'h4000_0000_0000_0000;
    in_op = 0; in_fmt = 1; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_a = 64'h4010_0000_0000_0000; in_op = 1;
    for (int i = 0; i < 3; i++) begin
      check("R8", "in_ready low under stall", 64'(in_ready), 64'd0);
      check("R8", "held result", out_result, 64'h3FF0_0000_0000_0000);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R8", "in_ready with drain", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "second op after release", out_result, 64'h4010_0000_0000_0000);
    @(negedge clk);

    // Random stream with random back-pressure
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit dp;
      bit mk;
      dp = $urandom % 2;
      mk = ($urandom % 4) != 0;
      in_fmt = dp;
      in_op = $urandom % 2;
      in_a = gen_val(dp);
      case ($urandom % 4)
        0: in_b = in_a;
        1: in_b = in_a ^ (dp ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000);
        default: in_b = gen_val(dp);
      endcase
      in_valid = mk;
      out_ready = ($urandom % 3) != 0;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R8", "unexpected output", out_result, 64'hX);
        end else begin
          logic [63:0] e;
          logic ei;
          string t;
          e = exp_q.pop_front();
          ei = inv_q.pop_front();
          t = tag_q.pop_front();
          check(t, "stream result", out_result, e);
          check(t, "stream invalid", 64'(out_invalid), 64'(ei));
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_res(in_a, in_b, in_op, dp));
        inv_q.push_back(is_snan(in_a, dp) || is_snan(in_b, dp));
        tag_q.push_back(tag_of(in_a, in_b, dp));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    if (out_valid && exp_q.size() == 1) begin
      check(tag_q.pop_front(), "final result", out_result, exp_q.pop_front());
    end
    @(negedge clk);
    check("R7", "idle after stream", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule